// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block produces one destination byte address per output pixel while a scaled image is written into a framebuffer. Pixels arrive in raster order of the unrotated image (left to right, top to bottom). The generator remaps each raster position through one of four rotations and, optionally, an 8x8 tile layout. It then scales the resulting pixel index by the bytes-per-pixel count and adds a base address.

A frame begins with a one-cycle start pulse. From then on the block presents addresses on a valid/ready output stream. Each handshake (`out_valid && out_ready`) means that the pixel at the presented address has been accepted. Back-pressure is unrestricted: while `out_ready` is low the current address and byte count hold still. After the final handshake a one-cycle done pulse marks completion, and the block returns to idle. If tiling is requested with a size that is not a multiple of 8, the start request is refused and an error flag is raised.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `done` and `err` are all 0.
- R2: A start pulse sampled while idle, with a legal configuration, sets `out_valid` from the next cycle on. The first address presented is the one for raster pixel (0,0).
- R3: Width W is `cfg_w_m1`+1 and height H is `cfg_h_m1`+1, each from 1 to 512. Raster pixel (x,y) maps to a destination (dx,dy) according to `cfg_rot`:
  - 0: (x,y), with destination width W.
  - 1 (90 degrees clockwise): (H-1-y, x), with destination width H.
  - 2 (180 degrees): (W-1-x, H-1-y), with destination width W.
  - 3 (270 degrees clockwise): (y, W-1-x), with destination width H.
- R4: With `cfg_tile`=0, the pixel index is dy*DW+dx, where DW is the destination width.
- R5: With `cfg_tile`=1, the pixel index is ((dy/8)*(DW/8)+dx/8)*64 + (dy%8)*8 + dx%8.
- R6: `cfg_mode` gives the bytes per pixel: 0 gives 4, 1 gives 3, and 2 or 3 give 2. `out_bytes` carries this count, and `out_addr` = `cfg_base` + index*bytes.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1, with `out_addr` and `out_bytes` unchanged.
- R8: `done` is 1 for exactly the cycle after the handshake of the final pixel (W*H handshakes in total). In that cycle `out_valid` is 0.
- R9: A start pulse sampled while idle with `cfg_tile`=1 and W or H not a multiple of 8 sets `err` to 1 and starts no frame. The next accepted start clears `err`.
- R10: The configuration is captured at the accepted start. Changes to the configuration inputs during a frame, and start pulses during a frame, have no effect on that frame's addresses or on `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle frame start request |
| cfg_w_m1 | input | 9 | Output width minus one |
| cfg_h_m1 | input | 10 | Output height minus one |
| cfg_rot | input | 2 | Rotation select (0, 90, 180, 270 degrees clockwise) |
| cfg_tile | input | 1 | 8x8 tiled layout enable |
| cfg_mode | input | 2 | Pixel size select |
| cfg_base | input | 32 | Framebuffer base byte address |
| out_valid | output | 1 | Address of the current pixel is presented |
| out_ready | input | 1 | Consumer accepts the current pixel |
| out_addr | output | 32 | Destination byte address |
| out_bytes | output | 3 | Bytes in this pixel |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last idle start was refused for tiling size |

## Verification
The address for a pixel is combinational from the registered raster counters. It is therefore due in the same cycle that `out_valid` shows it: first in the cycle after the start edge, and afterwards in the cycle after each handshake edge. `done` and `err` each come one register after their triggering edge: the final handshake for `done`, the start edge for `err`. The bench drives every input on the falling edge and samples outputs there too. It compares each accepted address with a reference function of the captured configuration and the raster position. It checks `done`, `out_valid` and `err` at the first falling edge after the edge that should change them, and checks `done` again one edge later.

// File: rtl/fbag_pkg.sv
package fbag_pkg;

  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;

  function automatic logic [2:0] bytes_of(input logic [1:0] mode);
    case (mode)
      2'd0:    bytes_of = 3'd4;
      2'd1:    bytes_of = 3'd3;
      default: bytes_of = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/fbag_ctrl.sv
module fbag_ctrl #(
  parameter int DIM_BITS  = 10,
  parameter int TILE_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                tile_req,
  input  logic [DIM_BITS-1:0] req_w_m1,
  input  logic [DIM_BITS-1:0] req_h_m1,
  input  logic [DIM_BITS-1:0] w_m1,
  input  logic [DIM_BITS-1:0] h_m1,
  input  logic                ready,
  output logic                busy,
  output logic                launch,
  output logic [DIM_BITS-1:0] x,
  output logic [DIM_BITS-1:0] y,
  output logic                done,
  output logic                err
);
  localparam logic [TILE_LOG2-1:0] TMASK = '1;

  logic bad_size, fire, last;

  assign bad_size = tile_req && ((req_w_m1[TILE_LOG2-1:0] != TMASK) ||
                                 (req_h_m1[TILE_LOG2-1:0] != TMASK));
  assign launch   = start && !busy && !bad_size;
  assign fire     = busy && ready;
  assign last     = (x == w_m1) && (y == h_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      x    <= '0;
      y    <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= fire && last;
      if (start && !busy) err <= bad_size;
      if (launch) begin
        busy <= 1'b1;
        x    <= '0;
        y    <= '0;
      end else if (fire) begin
        if (last) begin
          busy <= 1'b0;
        end else if (x == w_m1) begin
          x <= '0;
          y <= y + 1'b1;
        end else begin
          x <= x + 1'b1;
        end
      end
    end
  end

  p_pos_in_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (x <= w_m1) && (y <= h_m1));

  p_launch_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && (x == '0) && (y == '0));

endmodule

// File: rtl/fbag_map.sv
module fbag_map #(
  parameter int DIM_BITS  = 10,
  parameter int TILE_LOG2 = 3,
  parameter int IDX_W     = 2 * DIM_BITS
) (
  input  logic [DIM_BITS-1:0] x,
  input  logic [DIM_BITS-1:0] y,
  input  logic [DIM_BITS-1:0] w_m1,
  input  logic [DIM_BITS-1:0] h_m1,
  input  fbag_pkg::rot_e      rot,
  input  logic                tile,
  output logic [IDX_W-1:0]    idx
);
  import fbag_pkg::*;

  logic [DIM_BITS-1:0] dx, dy, dw, tpr;
  logic [IDX_W-1:0]    idx_lin, tile_num, idx_til;

  always_comb begin
    case (rot)
      ROT_90: begin
        dx = h_m1 - y;
        dy = x;
        dw = h_m1 + DIM_BITS'(1);
      end
      ROT_180: begin
        dx = w_m1 - x;
        dy = h_m1 - y;
        dw = w_m1 + DIM_BITS'(1);
      end
      ROT_270: begin
        dx = y;
        dy = w_m1 - x;
        dw = h_m1 + DIM_BITS'(1);
      end
      default: begin
        dx = x;
        dy = y;
        dw = w_m1 + DIM_BITS'(1);
      end
    endcase
  end

  assign tpr      = dw >> TILE_LOG2;
  assign idx_lin  = IDX_W'(dy) * IDX_W'(dw) + IDX_W'(dx);
  assign tile_num = IDX_W'(dy >> TILE_LOG2) * IDX_W'(tpr) + IDX_W'(dx >> TILE_LOG2);
  assign idx_til  = (tile_num << (2 * TILE_LOG2)) |
                    IDX_W'({dy[TILE_LOG2-1:0], dx[TILE_LOG2-1:0]});
  assign idx      = tile ? idx_til : idx_lin;

endmodule

// File: rtl/fbag_scale.sv
module fbag_scale #(
  parameter int IDX_W  = 20,
  parameter int ADDR_W = 32
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        nbytes
);
  localparam int OFF_W = IDX_W + 2;

  logic [OFF_W-1:0] off;

  assign nbytes = fbag_pkg::bytes_of(mode);

  always_comb begin
    case (nbytes)
      3'd4:    off = OFF_W'(idx) << 2;
      3'd3:    off = (OFF_W'(idx) << 1) + OFF_W'(idx);
      default: off = OFF_W'(idx) << 1;
    endcase
  end

  assign addr = base + ADDR_W'(off);

endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen #(
  parameter int W_FIELD   = 9,
  parameter int H_FIELD   = 10,
  parameter int ADDR_W    = 32,
  parameter int TILE_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [W_FIELD-1:0] cfg_w_m1,
  input  logic [H_FIELD-1:0] cfg_h_m1,
  input  logic [1:0]         cfg_rot,
  input  logic               cfg_tile,
  input  logic [1:0]         cfg_mode,
  input  logic [ADDR_W-1:0]  cfg_base,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [2:0]         out_bytes,
  output logic               done,
  output logic               err
);
  import fbag_pkg::*;

  localparam int DIM_BITS = (W_FIELD > H_FIELD) ? W_FIELD : H_FIELD;
  localparam int IDX_W    = 2 * DIM_BITS;

  logic [DIM_BITS-1:0] req_w_m1, req_h_m1, w_m1_q, h_m1_q, x, y;
  rot_e                rot_q;
  logic                tile_q, launch;
  logic [1:0]          mode_q;
  logic [ADDR_W-1:0]   base_q;
  logic [IDX_W-1:0]    idx;

  assign req_w_m1 = DIM_BITS'(cfg_w_m1);
  assign req_h_m1 = DIM_BITS'(cfg_h_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_m1_q <= '0;
      h_m1_q <= '0;
      rot_q  <= ROT_0;
      tile_q <= 1'b0;
      mode_q <= '0;
      base_q <= '0;
    end else if (launch) begin
      w_m1_q <= req_w_m1;
      h_m1_q <= req_h_m1;
      rot_q  <= rot_e'(cfg_rot);
      tile_q <= cfg_tile;
      mode_q <= cfg_mode;
      base_q <= cfg_base;
    end
  end

  fbag_ctrl #(.DIM_BITS(DIM_BITS), .TILE_LOG2(TILE_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .tile_req(cfg_tile),
    .req_w_m1(req_w_m1), .req_h_m1(req_h_m1), .w_m1(w_m1_q), .h_m1(h_m1_q),
    .ready(out_ready), .busy(out_valid), .launch(launch), .x(x), .y(y),
    .done(done), .err(err)
  );

  fbag_map #(.DIM_BITS(DIM_BITS), .TILE_LOG2(TILE_LOG2), .IDX_W(IDX_W)) u_map (
    .x(x), .y(y), .w_m1(w_m1_q), .h_m1(h_m1_q), .rot(rot_q), .tile(tile_q),
    .idx(idx)
  );

  fbag_scale #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_scale (
    .idx(idx), .mode(mode_q), .base(base_q), .addr(out_addr), .nbytes(out_bytes)
  );

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_bytes));

  p_done_closes_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_refused_no_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !out_valid);

  p_bytes_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bytes >= 3'd2) && (out_bytes <= 3'd4));

  p_idx_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(idx) < (32'(w_m1_q) + 1) * (32'(h_m1_q) + 1));

endmodule

// File: tb/sim_fb_addr_gen.sv
module sim_fb_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  cfg_w_m1 = '0;
  logic [9:0]  cfg_h_m1 = '0;
  logic [1:0]  cfg_rot = '0;
  logic        cfg_tile = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [31:0] cfg_base = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [2:0]  out_bytes;
  logic        done, err;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fb_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_w_m1(cfg_w_m1),
    .cfg_h_m1(cfg_h_m1), .cfg_rot(cfg_rot), .cfg_tile(cfg_tile),
    .cfg_mode(cfg_mode), .cfg_base(cfg_base), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_bytes(out_bytes),
    .done(done), .err(err)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bpp(input int mode);
    return (mode == 0) ? 4 : (mode == 1) ? 3 : 2;
  endfunction

  function automatic longint exp_addr(input int w, input int h, input int rot,
                                      input int tile, input int mode,
                                      input longint base, input int x, input int y);
    int dx, dy, dw, idx;
    case (rot)
      1: begin dx = h - 1 - y; dy = x;         dw = h; end
      2: begin dx = w - 1 - x; dy = h - 1 - y; dw = w; end
      3: begin dx = y;         dy = w - 1 - x; dw = h; end
      default: begin dx = x; dy = y; dw = w; end
    endcase
    if (tile != 0)
      idx = ((dy / 8) * (dw / 8) + dx / 8) * 64 + (dy % 8) * 8 + dx % 8;
    else
      idx = dy * dw + dx;
    return (base + longint'(idx) * bpp(mode)) & 64'hFFFF_FFFF;
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs one frame. Inputs change only at falling edges.
  task automatic run_frame(input int w, input int h, input int rot, input int tile,
                           input int mode, input longint base, input int stall_pct,
                           input bit disturb);
    int x = 0, y = 0, n = 0;
    int total = w * h;
    bit stalled = 1'b0;
    longint held = 0;
    @(negedge clk);
    cfg_w_m1 = 9'(w - 1); cfg_h_m1 = 10'(h - 1); cfg_rot = 2'(rot);
    cfg_tile = 1'(tile); cfg_mode = 2'(mode); cfg_base = 32'(base);
    out_ready = 1'b0;
    pulse_start();
    check("R2", "valid after start", out_valid, 1);
    check("R9", "err cleared by accepted start", err, 0);
    if (disturb) begin
      cfg_w_m1 = 9'($urandom); cfg_h_m1 = 10'($urandom); cfg_rot = 2'($urandom);
      cfg_tile = 1'($urandom); cfg_mode = 2'($urandom); cfg_base = $urandom;
    end
    while (n < total && !finished) begin
      if (disturb && n == total / 2) start = 1'b1; else start = 1'b0;
      out_ready = (($urandom % 100) >= stall_pct);
      if (stalled) check("R7", "addr held under stall", out_addr, held);
      check("R3", "valid during frame", out_valid, 1);
      if (out_ready) begin
        check(tile != 0 ? "R5" : "R4", "address", out_addr,
              exp_addr(w, h, rot, tile, mode, base, x, y));
        check("R6", "byte count", out_bytes, bpp(mode));
        n++;
        if (x == w - 1) begin x = 0; y++; end else x++;
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        held = out_addr;
      end
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    check("R8", "done after last pixel", done, 1);
    check("R8", "valid low with done", out_valid, 0);
    if (disturb) check("R10", "err unaffected by busy start", err, 0);
    @(negedge clk);
    check("R8", "done lasts one cycle", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", out_valid, 0);
    check("R1", "done after reset", done, 0);
    check("R1", "err after reset", err, 0);

    // Directed: each rotation in linear and tiled form, each pixel mode.
    for (int r = 0; r < 4; r++) begin
      run_frame(5, 3, r, 0, r, 64'h1000, 0, 1'b0);
      run_frame(16, 8, r, 1, 3 - r, 64'h8000_0000, 30, 1'b0);
    end
    // Extremes of the size range.
    run_frame(1, 1, 0, 0, 0, 64'h40, 0, 1'b0);
    run_frame(512, 1, 1, 0, 1, 64'h100, 10, 1'b0);
    run_frame(1, 512, 3, 0, 2, 64'h200, 10, 1'b0);
    run_frame(512, 8, 1, 1, 0, 64'hFFFF_F000, 5, 1'b0);

    // Refused start: tiling with width 12.
    @(negedge clk);
    cfg_w_m1 = 9'd11; cfg_h_m1 = 10'd7; cfg_tile = 1'b1;
    pulse_start();
    check("R9", "err on bad tiled width", err, 1);
    check("R9", "no frame on refusal", out_valid, 0);
    @(negedge clk);
    check("R9", "still idle after refusal", out_valid, 0);
    cfg_w_m1 = 9'd7; cfg_h_m1 = 10'd9;
    pulse_start();
    check("R9", "err on bad tiled height", err, 1);
    check("R9", "no frame on bad height", out_valid, 0);
    run_frame(8, 8, 2, 1, 0, 64'h0, 20, 1'b0);

    // Constrained random frames, with disturbance during some of them.
    for (int i = 0; i < 40 && !finished; i++) begin
      int t = $urandom % 2;
      int w = t ? 8 * (1 + $urandom % 3) : 1 + $urandom % 24;
      int h = t ? 8 * (1 + $urandom % 3) : 1 + $urandom % 24;
      run_frame(w, h, $urandom % 4, t, $urandom % 4, longint'($urandom),
                $urandom % 60, 1'($urandom % 2));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule